// File: doc/BRIEF.md
# PCM Self-Test Minor Frame Generator

This block produces a repeating serial PCM minor frame for loop-back testing of a telemetry receive chain. Every frame opens with a programmable synchronisation pattern and is followed by a programmable number of data words of programmable width. Each frame has the same layout; there is no major-frame sequencing.

The first eight data words of each frame hold rolling counters, so a receiver can watch them advance from frame to frame. Every later word holds a fixed fill value. One bit goes out every `CLKS_PER_BIT` clock cycles. A one-cycle strobe marks each new bit, and a level marker is high for the whole first sync bit. The frame layout inputs and the enable are sampled only when a frame starts, so a frame is never cut off or mixed from two layouts.

Top module: `pcm_loopback_gen`

## Requirements
- R1: After reset, and while `enable` has been low since reset, `bitStrobe`, `serData` and `frameStart` stay 0.
- R2: While frames run, exactly one bit goes out every `CLKS_PER_BIT` clocks (default 4). `bitStrobe` is high for one clock in the cycle a new bit appears on `serData`, and `serData` holds that bit until the next strobe.
- R3: Each frame begins with the low `syncLen` bits of `syncPattern` (1 to 64 bits), most significant first, so bit `syncLen-1` is sent first.
- R4: `frameStart` is 1 for the first sync bit of a frame and 0 for every other bit.
- R5: After the sync bits come exactly `wordsPerFrame` words (1 to 255) of `wordLen` bits (4 to 16), each sent MSB first. While enabled, the next frame's first sync bit follows the last word bit with no gap.
- R6: Word index k (counting from 0) with k < 8 carries (n + k) mod 2^wordLen. Here n is the number of frames completed since reset, so each counter wraps to zero.
- R7: Word index k with k >= 8 carries 0x1234 reduced mod 2^wordLen.
- R8: `syncPattern`, `syncLen`, `wordLen` and `wordsPerFrame` are sampled at the first bit of a frame. Changes made during a frame take effect only from the next frame.
- R9: `enable` is sampled only at a frame boundary. If it drops mid-frame, the frame completes and output then stops. When it rises again, frames resume and the counters continue from the number of completed frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run frames; sampled at frame boundaries |
| syncPattern | input | 64 | Sync pattern, right-justified |
| syncLen | input | 7 | Sync length in bits, 1 to 64 |
| wordLen | input | 5 | Data word width in bits, 4 to 16 |
| wordsPerFrame | input | 8 | Data words per frame, 1 to 255 |
| serData | output | 1 | Serial data line |
| bitStrobe | output | 1 | One-clock pulse marking each new bit |
| frameStart | output | 1 | High during the first sync bit |

## Verification
A wrong bit counter or word index shows up within one frame. A field has the wrong length, so every later word is misaligned and the next frame's marker arrives early or late. A fault in the frame counter shows only in the counter words, one frame later. The wrap case appears only after 16 frames at a 4-bit width, so the run covers that many frames. A layout register that reloads at the wrong moment corrupts the frame in which the inputs change, and the layout-change frames check exactly that.

// File: rtl/pcm_lb_pkg.sv
package pcm_lb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_DATA = 2'd2
  } lbPhase_e;

  // strobes from control to datapath, all valid in a single clock
  typedef struct packed {
    logic tick;      // bit boundary
    logic loadSync;  // first sync bit of a new frame
    logic loadWord;  // first bit of a data word
    logic shift;     // next bit of the current field
    logic frameEnd;  // last bit of the frame has been sent
  } lbStrobe_t;

endpackage

// File: rtl/pcm_lb_ctrl.sv
module pcm_lb_ctrl
  import pcm_lb_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  parameter int SYNC_MAX     = 64,
  parameter int WORD_MAX     = 16,
  parameter int WORDS_MAX    = 255,
  localparam int SLW = $clog2(SYNC_MAX + 1),
  localparam int WLW = $clog2(WORD_MAX + 1),
  localparam int NWW = $clog2(WORDS_MAX + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic [SLW-1:0] syncLen,
  input  logic [WLW-1:0] wordLen,
  input  logic [NWW-1:0] wordsPerFrame,
  output lbStrobe_t      strb,
  output logic [NWW-1:0] wordSel,
  output logic [WLW-1:0] wordLenQ
);

  localparam int DW  = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BLW = (SLW > WLW) ? SLW : WLW;

  logic [DW-1:0]  divCnt;
  logic           tick;
  lbPhase_e       phase;
  logic [BLW-1:0] bitLeft;
  logic [NWW-1:0] wordIdx;
  logic [NWW-1:0] nWordsQ;
  logic           lastBit;
  logic           frameDone;

  // bit-rate divider, free running
  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + DW'(1);
  end
  assign tick = (divCnt == DW'(CLKS_PER_BIT - 1));

  assign lastBit   = (bitLeft == '0);
  assign frameDone = (phase == PH_DATA) && lastBit && (wordIdx == nWordsQ - NWW'(1));
  assign wordSel   = (phase == PH_SYNC) ? '0 : wordIdx + NWW'(1);

  always_comb begin
    strb      = '0;
    strb.tick = tick;
    if (tick) begin
      case (phase)
        PH_IDLE: strb.loadSync = enable;
        PH_SYNC: begin
          strb.loadWord = lastBit;
          strb.shift    = !lastBit;
        end
        PH_DATA: begin
          if (!lastBit) strb.shift = 1'b1;
          else if (!frameDone) strb.loadWord = 1'b1;
          else begin
            strb.frameEnd = 1'b1;
            strb.loadSync = enable;
          end
        end
        default: strb.loadSync = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitLeft  <= '0;
      wordIdx  <= '0;
      nWordsQ  <= NWW'(1);
      wordLenQ <= WLW'(WORD_MAX);
    end else if (strb.loadSync) begin
      phase    <= PH_SYNC;
      bitLeft  <= BLW'(syncLen) - BLW'(1);
      wordLenQ <= wordLen;
      nWordsQ  <= wordsPerFrame;
    end else if (strb.loadWord) begin
      phase   <= PH_DATA;
      bitLeft <= BLW'(wordLenQ) - BLW'(1);
      wordIdx <= wordSel;
    end else if (strb.shift) begin
      bitLeft <= bitLeft - BLW'(1);
    end else if (strb.frameEnd) begin
      phase <= PH_IDLE;
    end
  end

  // R5: a word index never runs past the latched word count
  a_r5_word_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (wordIdx < nWordsQ));

  // R9: a frame never starts while disabled
  a_r9_start_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSync |-> enable);

endmodule

// File: rtl/pcm_lb_data.sv
module pcm_lb_data
  import pcm_lb_pkg::*;
#(
  parameter int          SYNC_MAX  = 64,
  parameter int          WORD_MAX  = 16,
  parameter int          WORDS_MAX = 255,
  parameter int          NCOUNT    = 8,
  parameter logic [15:0] FILL      = 16'h1234,
  localparam int SLW = $clog2(SYNC_MAX + 1),
  localparam int WLW = $clog2(WORD_MAX + 1),
  localparam int NWW = $clog2(WORDS_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  lbStrobe_t           strb,
  input  logic [SYNC_MAX-1:0] syncPattern,
  input  logic [SLW-1:0]      syncLen,
  input  logic [WLW-1:0]      wordLenQ,
  input  logic [NWW-1:0]      wordSel,
  output logic                serData,
  output logic                bitStrobe,
  output logic                frameStart
);

  logic [SYNC_MAX-1:0] shReg;
  logic [WORD_MAX-1:0] frameCnt;
  logic [WORD_MAX-1:0] wordMask;
  logic [WORD_MAX-1:0] wordVal;
  logic [WORD_MAX-1:0] wordAligned;
  logic [SYNC_MAX-1:0] wordLoad;
  logic [SYNC_MAX-1:0] syncLoad;
  logic                emit;

  assign wordMask    = WORD_MAX'((32'd1 << wordLenQ) - 32'd1);
  assign wordVal     = ((wordSel < NWW'(NCOUNT)) ? frameCnt + WORD_MAX'(wordSel)
                                                 : WORD_MAX'(FILL)) & wordMask;
  assign wordAligned = wordVal << (WLW'(WORD_MAX) - wordLenQ);
  assign wordLoad    = {wordAligned, {(SYNC_MAX - WORD_MAX){1'b0}}};
  assign syncLoad    = syncPattern << (SLW'(SYNC_MAX) - syncLen);
  assign emit        = strb.loadSync | strb.loadWord | strb.shift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg      <= '0;
      serData    <= 1'b0;
      bitStrobe  <= 1'b0;
      frameStart <= 1'b0;
      frameCnt   <= '0;
    end else begin
      bitStrobe <= emit;
      if (strb.frameEnd) frameCnt <= frameCnt + WORD_MAX'(1);
      if (strb.tick) begin
        frameStart <= strb.loadSync;
        if (strb.loadSync) begin
          serData <= syncLoad[SYNC_MAX-1];
          shReg   <= syncLoad << 1;
        end else if (strb.loadWord) begin
          serData <= wordLoad[SYNC_MAX-1];
          shReg   <= wordLoad << 1;
        end else if (strb.shift) begin
          serData <= shReg[SYNC_MAX-1];
          shReg   <= shReg << 1;
        end else begin
          serData <= 1'b0;
        end
      end
    end
  end

  // R2: a strobe never lasts two clocks
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe);

  // R4: a frame start puts the marker up together with a bit strobe
  a_r4_marker_on_start: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSync |=> (frameStart && bitStrobe));

  // R6: the frame counter steps by exactly one per finished frame
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameEnd |=> (frameCnt == $past(frameCnt) + WORD_MAX'(1)));

endmodule

// File: rtl/pcm_loopback_gen.sv
module pcm_loopback_gen
  import pcm_lb_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  parameter int SYNC_MAX     = 64,
  parameter int WORD_MAX     = 16,
  parameter int WORDS_MAX    = 255,
  localparam int SLW = $clog2(SYNC_MAX + 1),
  localparam int WLW = $clog2(WORD_MAX + 1),
  localparam int NWW = $clog2(WORDS_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [SYNC_MAX-1:0] syncPattern,
  input  logic [SLW-1:0]      syncLen,
  input  logic [WLW-1:0]      wordLen,
  input  logic [NWW-1:0]      wordsPerFrame,
  output logic                serData,
  output logic                bitStrobe,
  output logic                frameStart
);

  lbStrobe_t      strb;
  logic [NWW-1:0] wordSel;
  logic [WLW-1:0] wordLenQ;

  pcm_lb_ctrl #(
    .CLKS_PER_BIT(CLKS_PER_BIT), .SYNC_MAX(SYNC_MAX),
    .WORD_MAX(WORD_MAX), .WORDS_MAX(WORDS_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .syncLen(syncLen),
    .wordLen(wordLen), .wordsPerFrame(wordsPerFrame),
    .strb(strb), .wordSel(wordSel), .wordLenQ(wordLenQ)
  );

  pcm_lb_data #(
    .SYNC_MAX(SYNC_MAX), .WORD_MAX(WORD_MAX), .WORDS_MAX(WORDS_MAX)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .syncPattern(syncPattern),
    .syncLen(syncLen), .wordLenQ(wordLenQ), .wordSel(wordSel),
    .serData(serData), .bitStrobe(bitStrobe), .frameStart(frameStart)
  );

endmodule

// File: tb/tb_pcm_loopback_gen.sv
module tb_pcm_loopback_gen;

  localparam int CLKS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [63:0] syncPattern = '0;
  logic [6:0]  syncLen = 7'd16;
  logic [4:0]  wordLen = 5'd16;
  logic [7:0]  wordsPerFrame = 8'd1;
  logic        serData, bitStrobe, frameStart;

  int nCheck = 0;
  int nFail = 0;
  int gapCnt = 0;
  int lastGap = 0;

  always #5 clk = ~clk;

  pcm_loopback_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .syncPattern(syncPattern),
    .syncLen(syncLen), .wordLen(wordLen), .wordsPerFrame(wordsPerFrame),
    .serData(serData), .bitStrobe(bitStrobe), .frameStart(frameStart)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nCheck++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] maskOf(input int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  task automatic getBit(output logic b, output logic fs);
    gapCnt = 0;
    forever begin
      @(negedge clk);
      gapCnt++;
      if (bitStrobe) break;
    end
    lastGap = gapCnt;
    b = serData;
    fs = frameStart;
  endtask

  // captures one frame; optionally changes inputs right after its first bit
  task automatic captureFrame(input int sl, input int wl, input int nw,
                              input logic [63:0] pat, input int n,
                              input bit doChange, input int nSl, input int nWl,
                              input int nNw, input logic [63:0] nPat, input logic nEn);
    logic b, fs;
    logic [63:0] acc;
    bit badGap, badFs;
    getBit(b, fs);
    chk($sformatf("R4 frameStart on first sync bit, frame %0d", n), 64'(fs), 64'd1);
    if (doChange) begin
      syncLen = 7'(nSl); wordLen = 5'(nWl); wordsPerFrame = 8'(nNw);
      syncPattern = nPat; enable = nEn;
    end
    acc = 64'(b);
    badGap = 0; badFs = 0;
    for (int i = 1; i < sl; i++) begin
      getBit(b, fs);
      acc = {acc[62:0], b};
      if (lastGap != CLKS) badGap = 1;
      if (fs) badFs = 1;
    end
    chk($sformatf("R3 sync field, frame %0d (R8 layout held)", n), acc, pat & maskOf(sl));
    for (int k = 0; k < nw; k++) begin
      logic [63:0] exp;
      acc = '0;
      for (int j = 0; j < wl; j++) begin
        getBit(b, fs);
        acc = {acc[62:0], b};
        if (lastGap != CLKS) badGap = 1;
        if (fs) badFs = 1;
      end
      if (k < 8) begin
        exp = 64'(n + k) & maskOf(wl);
        chk($sformatf("R6 counter word %0d frame %0d", k, n), acc, exp);
      end else begin
        exp = 64'h1234 & maskOf(wl);
        chk($sformatf("R7 fill word %0d frame %0d", k, n), acc, exp);
      end
    end
    chk($sformatf("R2 bit spacing in frame %0d", n), 64'(badGap), 64'd0);
    chk($sformatf("R4 frameStart low after first bit, frame %0d", n), 64'(badFs), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCheck++; nFail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

  initial begin
    int seen;
    logic b, fs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet while disabled
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bitStrobe || serData || frameStart) seen++;
    end
    chk("R1 outputs quiet after reset while disabled", 64'(seen), 64'd0);

    // layout A
    syncPattern = 64'hEB90; syncLen = 7'd16; wordLen = 5'd16; wordsPerFrame = 8'd10;
    enable = 1'b1;
    captureFrame(16, 16, 10, 64'hEB90, 0, 0, 0, 0, 0, '0, 1'b1);
    // R8: layout B applied mid-frame, frame 1 still layout A
    captureFrame(16, 16, 10, 64'hEB90, 1, 1, 64, 8, 8, 64'hFE6B_2840_A5C3_1E77, 1'b1);
    captureFrame(64, 8, 8, 64'hFE6B_2840_A5C3_1E77, 2, 0, 0, 0, 0, '0, 1'b1);
    // R5: frames are back to back; the next frame marker proves the length
    captureFrame(64, 8, 8, 64'hFE6B_2840_A5C3_1E77, 3, 1, 1, 4, 12, 64'h1, 1'b1);
    // layout C: one sync bit, 4-bit words, counters wrap (R6)
    for (int f = 4; f < 24; f++) begin
      if (f == 23) captureFrame(1, 4, 12, 64'h1, f, 1, 24, 12, 3, 64'hFAF320, 1'b1);
      else captureFrame(1, 4, 12, 64'h1, f, 0, 0, 0, 0, '0, 1'b1);
    end
    // R9: drop enable mid-frame, frame still completes
    captureFrame(24, 12, 3, 64'hFAF320, 24, 1, 24, 12, 3, 64'hFAF320, 1'b0);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bitStrobe) seen++;
    end
    chk("R9 no bits after frame completes with enable low", 64'(seen), 64'd0);
    enable = 1'b1;
    captureFrame(24, 12, 3, 64'hFAF320, 25, 0, 0, 0, 0, '0, 1'b1);
    getBit(b, fs);
    chk("R5 next frame follows last word at once", 64'({fs, lastGap == CLKS}), 64'd3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

endmodule